// File: doc/BRIEF.md
# Peripheral Control-Line Handshake and Interrupt Unit

This block holds the control-line logic for one port of a parallel I/O adapter. The port has two control lines: C1, which is always an input, and C2, which is either a second interrupt input or a handshake output. The unit watches each input line for its programmed active edge and latches an interrupt flag for it. It drives an active-low interrupt request from the flags and their enable bits. It also generates the C2 output level in manual, read-strobe or write-strobe modes. The surrounding register decode holds the port's control register, so the control bits arrive here as plain levels. The host bus timing arrives as single-cycle ticks for the enable strobe's rising and falling edges, together with a level telling whether the part is selected during the current enable pulse. Data-register read and write pulses also arrive as single-cycle ticks.

One parameter picks the port role. A read-strobe port asserts its C2 strobe on a falling enable tick after a data read. A write-strobe port asserts it on a rising enable tick after a data write. All other logic is shared between the two roles. The block has no data stream, so every pin is a plain control or status level, with no valid/ready handshake and no back-pressure.

Top module: `hsk_ctl_unit`

## Requirements
- R1: After reset, flag_c1 and flag_c2 are 0, irq_n is 1 and c2_oe is 0.
- R2: flag_c1 is set by the C1 edge into the level given by control bit 1 (cr1: 1 = rising, 0 = falling). The edge counts only if an enable tick (en_rise or en_fall) was seen while the synchronised line sat at the opposite level. The flag is visible on the third rising clock edge after the pin change.
- R3: With cr5 = 0, flag_c2 is set in the same way by C2, with its active level given by cr4. While cr5 = 1, flag_c2 is cleared one cycle later and stays 0.
- R4: irq_n is 0 exactly when (flag_c1 and cr0) or (flag_c2 and cr3 and not cr5). It follows the control bits in the same cycle, so setting cr3 while flag_c2 is already set lowers irq_n at once.
- R5: A dat_rd tick clears both flags on the next clock edge. Afterwards no flag can be set until an en_fall tick has arrived with sel = 0.
- R6: With cr5,cr4 = 1,1, c2_oe is 1 and c2_out takes the value of cr3 one clock later. With cr5 = 0, c2_oe is 0.
- R7: Read-strobe role with cr5,cr4,cr3 = 1,0,0: c2_out goes to 0 on the first en_fall tick after a dat_rd tick. It returns to 1 on the third clock edge after the C1 pin makes its armed active transition.
- R8: With cr5,cr4,cr3 = 1,0,1, a low strobe returns to 1 on the first strobe-edge tick that follows a completed enable pulse during which sel was 0. Strobe-edge ticks before that keep it low.
- R9: Write-strobe role with cr5,cr4 = 1,0: dat_wr takes the place of dat_rd and en_rise takes the place of en_fall as the strobe edge. Both restore rules of R7 and R8 apply unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cr0 | input | 1 | Control bit 0: C1 interrupt enable |
| cr1 | input | 1 | Control bit 1: C1 active edge, 1 = rising |
| cr3 | input | 1 | Control bit 3: C2 interrupt enable / manual level / restore select |
| cr4 | input | 1 | Control bit 4: C2 active edge, or manual mode when cr5 = 1 |
| cr5 | input | 1 | Control bit 5: 1 = C2 is an output |
| dat_rd | input | 1 | Tick: host read of the port data register |
| dat_wr | input | 1 | Tick: host write of the port output register |
| en_rise | input | 1 | Tick: rising edge of the host enable strobe |
| en_fall | input | 1 | Tick: falling edge of the host enable strobe |
| sel | input | 1 | Part selected during the current enable pulse |
| c1_pin | input | 1 | C1 line, asynchronous |
| c2_pin | input | 1 | C2 line as an input, asynchronous |
| c2_out | output | 1 | C2 level when driven |
| c2_oe | output | 1 | C2 output enable |
| flag_c1 | output | 1 | C1 interrupt flag (read back as control bit 7) |
| flag_c2 | output | 1 | C2 interrupt flag (read back as control bit 6) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A pin edge on C1 or C2 passes two synchroniser flops and one history flop, so the resulting flag, and the strobe restore it causes, is due on the third rising clock edge after the pin change. The bench changes pins at a falling clock edge and samples exactly three falling edges later, and in one case also samples after two edges to see that the change is not early. Data ticks and control-bit changes act on the next clock edge and are sampled one falling edge later. irq_n is combinational from the flags and control bits, so it is sampled a moment after a control bit changes, with no clock edge in between. Each strobe step is sampled right after the single enable tick that should or should not move it.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  // Which data access and which enable edge launch the C2 strobe.
  typedef enum logic {
    ROLE_RD_STROBE = 1'b0,  // strobe after data read, on falling enable tick
    ROLE_WR_STROBE = 1'b1   // strobe after data write, on rising enable tick
  } port_role_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsk_edge_arm.sv
// Edge detector that only fires after being conditioned by an enable tick
// seen while the line sat at its inactive level.
module hsk_edge_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,       // synchronised line
  input  logic act_hi,    // 1: rising edge is active
  input  logic arm_tick,  // any enable tick
  output logic hit
);
  logic prev_q, armed_q;
  logic at_active;

  assign at_active = (lvl == act_hi);
  assign hit       = armed_q & at_active & (prev_q != act_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (at_active)     armed_q <= 1'b0;
      else if (arm_tick) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hsk_c2_drive.sv
// C2 output level: manual, strobe with C1 restore, strobe with enable restore.
module hsk_c2_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic cr3,
  input  logic cr4,
  input  logic cr5,
  input  logic access,     // data access that launches a strobe
  input  logic sedge,      // enable tick that moves the strobe
  input  logic desel_end,  // end of an enable pulse while deselected
  input  logic c1_hit,     // armed active C1 transition
  output logic c2_level
);
  logic pend_q, dsl_q, lvl_q;
  logic strobe_md, manual_md, assert_now;

  assign strobe_md  = cr5 & ~cr4;
  assign manual_md  = cr5 & cr4;
  assign assert_now = sedge & pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dsl_q  <= 1'b0;
      lvl_q  <= 1'b1;
    end else if (!strobe_md) begin
      pend_q <= 1'b0;
      dsl_q  <= 1'b0;
      lvl_q  <= manual_md ? cr3 : 1'b1;
    end else begin
      if (assert_now)  pend_q <= 1'b0;
      else if (access) pend_q <= 1'b1;

      if (assert_now)     dsl_q <= 1'b0;
      else if (desel_end) dsl_q <= 1'b1;

      if (assert_now)                       lvl_q <= 1'b0;
      else if (!lvl_q && !cr3 && c1_hit)    lvl_q <= 1'b1;
      else if (!lvl_q && cr3 && sedge && dsl_q) lvl_q <= 1'b1;
    end
  end

  assign c2_level = lvl_q;

  assert_manual_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr5 && cr4) |=> (lvl_q == $past(cr3)));

  // Also covers the write-strobe role of R9 through sedge.
  assert_strobe_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_md && pend_q && sedge) |=> !lvl_q);

  assert_restore_needs_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_md && cr3 && !lvl_q && !dsl_q) |=> !lvl_q);
endmodule

// File: rtl/hsk_ctl_unit.sv
module hsk_ctl_unit
  import hsk_pkg::*;
#(
  parameter port_role_e  ROLE        = ROLE_RD_STROBE,
  parameter int unsigned SYNC_STAGES = MIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cr0,
  input  logic cr1,
  input  logic cr3,
  input  logic cr4,
  input  logic cr5,
  input  logic dat_rd,
  input  logic dat_wr,
  input  logic en_rise,
  input  logic en_fall,
  input  logic sel,
  input  logic c1_pin,
  input  logic c2_pin,
  output logic c2_out,
  output logic c2_oe,
  output logic flag_c1,
  output logic flag_c2,
  output logic irq_n
);
  localparam bit WR_ROLE = (ROLE == ROLE_WR_STROBE);

  logic c1_s, c2_s, c1_hit, c2_hit, arm_tick;
  logic blk_q, f1_q, f2_q;
  logic access, sedge, desel_end;

  assign arm_tick  = en_rise | en_fall;
  assign desel_end = en_fall & ~sel;
  assign access    = WR_ROLE ? dat_wr  : dat_rd;
  assign sedge     = WR_ROLE ? en_rise : en_fall;

  hsk_sync #(.STAGES(SYNC_STAGES)) u_sync_c1 (.clk(clk), .rst_n(rst_n), .d(c1_pin), .q(c1_s));
  hsk_sync #(.STAGES(SYNC_STAGES)) u_sync_c2 (.clk(clk), .rst_n(rst_n), .d(c2_pin), .q(c2_s));

  hsk_edge_arm u_edge_c1 (.clk(clk), .rst_n(rst_n), .lvl(c1_s), .act_hi(cr1),
                          .arm_tick(arm_tick), .hit(c1_hit));
  hsk_edge_arm u_edge_c2 (.clk(clk), .rst_n(rst_n), .lvl(c2_s), .act_hi(cr4),
                          .arm_tick(arm_tick), .hit(c2_hit));

  // Flags and the post-read block.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
    end else begin
      if (dat_rd)         blk_q <= 1'b1;
      else if (desel_end) blk_q <= 1'b0;

      if (dat_rd)                f1_q <= 1'b0;
      else if (c1_hit && !blk_q) f1_q <= 1'b1;

      if (dat_rd || cr5)                 f2_q <= 1'b0;
      else if (c2_hit && !blk_q)         f2_q <= 1'b1;
    end
  end

  hsk_c2_drive u_c2 (
    .clk(clk), .rst_n(rst_n), .cr3(cr3), .cr4(cr4), .cr5(cr5),
    .access(access), .sedge(sedge), .desel_end(desel_end),
    .c1_hit(c1_hit), .c2_level(c2_out)
  );

  assign c2_oe   = cr5;
  assign flag_c1 = f1_q;
  assign flag_c2 = f2_q;
  assign irq_n   = ~((f1_q & cr0) | (f2_q & cr3 & ~cr5));

  assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rd |=> (!flag_c1 && !flag_c2));

  assert_no_set_while_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !flag_c1) |=> !flag_c1);

  assert_c2flag_output_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cr5 |=> !flag_c2);

  assert_irq_c1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_c1 && cr0) |-> !irq_n);

  assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_c1 && !flag_c2) |-> irq_n);

  assert_c1_needs_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_c1 && !c1_hit) |=> !flag_c1);
endmodule

// File: tb/hsk_ctl_unit_test.sv
`timescale 1ns/1ps
module hsk_ctl_unit_test;
  import hsk_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a0 = 0, a1 = 0, a3 = 0, a4 = 0, a5 = 0;
  logic b0 = 0, b1 = 0, b3 = 0, b4 = 0, b5 = 0;
  logic dat_rd = 0, dat_wr = 0, en_rise = 0, en_fall = 0, sel = 0;
  logic c1 = 0, c2 = 0;
  logic c2o_a, c2e_a, f1_a, f2_a, irq_a;
  logic c2o_b, c2e_b, f1_b, f2_b, irq_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  hsk_ctl_unit #(.ROLE(ROLE_RD_STROBE)) uut (
    .clk(clk), .rst_n(rst_n), .cr0(a0), .cr1(a1), .cr3(a3), .cr4(a4), .cr5(a5),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .en_rise(en_rise), .en_fall(en_fall), .sel(sel),
    .c1_pin(c1), .c2_pin(c2), .c2_out(c2o_a), .c2_oe(c2e_a),
    .flag_c1(f1_a), .flag_c2(f2_a), .irq_n(irq_a));

  hsk_ctl_unit #(.ROLE(ROLE_WR_STROBE)) uut_b (
    .clk(clk), .rst_n(rst_n), .cr0(b0), .cr1(b1), .cr3(b3), .cr4(b4), .cr5(b5),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .en_rise(en_rise), .en_fall(en_fall), .sel(sel),
    .c1_pin(c1), .c2_pin(c2), .c2_out(c2o_b), .c2_oe(c2e_b),
    .flag_c1(f1_b), .flag_c2(f2_b), .irq_n(irq_b));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_a(input logic v5, v4, v3, v1, v0);
    a5 = v5; a4 = v4; a3 = v3; a1 = v1; a0 = v0;
  endtask

  task automatic set_b(input logic v5, v4, v3, v1, v0);
    b5 = v5; b4 = v4; b3 = v3; b1 = v1; b0 = v0;
  endtask

  task automatic rise_tick(input logic s);
    sel = s; en_rise = 1'b1; cyc(1); en_rise = 1'b0;
  endtask

  task automatic fall_tick(input logic s);
    sel = s; en_fall = 1'b1; cyc(1); en_fall = 1'b0; sel = 1'b0;
  endtask

  task automatic en_pulse(input logic s);
    rise_tick(s); fall_tick(s);
  endtask

  task automatic rd_tick();
    dat_rd = 1'b1; cyc(1); dat_rd = 1'b0;
  endtask

  task automatic wr_tick();
    dat_wr = 1'b1; cyc(1); dat_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    check(f1_a, 1'b0, "R1 flag_c1 reset");
    check(f2_a, 1'b0, "R1 flag_c2 reset");
    check(irq_a, 1'b1, "R1 irq_n reset");
    check(c2e_a, 1'b0, "R1 c2_oe reset");
    rst_n = 1'b1;
    cyc(2);

    // Sweep: polarity x armed x both interrupt enables (R2, R3, R4).
    for (int pol = 0; pol < 2; pol++) begin
      for (int arm = 0; arm < 2; arm++) begin
        for (int ie = 0; ie < 4; ie++) begin
          logic p, ar, e1, e2;
          p = pol[0]; ar = arm[0]; e1 = ie[0]; e2 = ie[1];
          set_a(1'b0, p, e2, p, e1);
          c1 = p; c2 = p; cyc(4);
          rd_tick();
          check(f1_a, 1'b0, "R5 read clears flag_c1");
          en_pulse(1'b0);             // unblock while lines active: no arming
          c1 = ~p; c2 = ~p; cyc(4);
          if (ar) en_pulse(1'b1);     // condition the edge detectors
          c1 = p; c2 = p; cyc(3);
          check(f1_a, ar, "R2 flag_c1 after edge");
          check(f2_a, ar, "R3 flag_c2 after edge");
          check(irq_a, ~(ar & (e1 | e2)), "R4 irq_n from flags");
          if (ar && !e2) begin
            a3 = 1'b1; #1;
            check(irq_a, 1'b0, "R4 late enable of C2 interrupt");
          end
        end
      end
    end

    // R5: block after read until a deselected enable pulse.
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    c1 = 1'b0; c2 = 1'b0; cyc(4);
    en_pulse(1'b1);
    rd_tick();
    c1 = 1'b1; cyc(3);
    check(f1_a, 1'b0, "R5 no set while blocked");
    check(irq_a, 1'b1, "R5 irq_n while blocked");
    c1 = 1'b0; cyc(4);
    en_pulse(1'b0);
    c1 = 1'b1; cyc(3);
    check(f1_a, 1'b1, "R5 set after deselected pulse");
    check(irq_a, 1'b0, "R5 irq_n after deselected pulse");

    // R3 output mode clears flag_c2; R6 manual mode.
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    c2 = 1'b0; cyc(4);
    en_pulse(1'b0);
    c2 = 1'b1; cyc(3);
    check(f2_a, 1'b1, "R3 flag_c2 set before output mode");
    check(irq_a, 1'b0, "R4 irq_n from flag_c2");
    set_a(1'b1, 1'b1, 1'b1, 1'b1, 1'b0); cyc(1);
    check(f2_a, 1'b0, "R3 flag_c2 cleared in output mode");
    check(c2e_a, 1'b1, "R6 c2_oe in manual");
    check(c2o_a, 1'b1, "R6 manual high");
    a3 = 1'b0; cyc(1);
    check(c2o_a, 1'b0, "R6 manual low");
    a3 = 1'b1; cyc(1);
    check(c2o_a, 1'b1, "R6 manual high again");

    // R7: read strobe, C1 restore.
    set_a(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    c1 = 1'b0; cyc(4);
    en_pulse(1'b1);
    check(c2o_a, 1'b1, "R7 idle high");
    rd_tick();
    check(c2o_a, 1'b1, "R7 high until enable falls");
    rise_tick(1'b1);
    check(c2o_a, 1'b1, "R7 rising tick ignored");
    fall_tick(1'b1);
    check(c2o_a, 1'b0, "R7 low after falling tick");
    c1 = 1'b1; cyc(2);
    check(c2o_a, 1'b0, "R7 not restored early");
    cyc(1);
    check(c2o_a, 1'b1, "R7 restored by C1 edge");

    // R8: read strobe, enable restore.
    set_a(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    rd_tick();
    en_pulse(1'b1);
    check(c2o_a, 1'b0, "R8 strobe low");
    en_pulse(1'b1);
    check(c2o_a, 1'b0, "R8 held low without deselect");
    en_pulse(1'b0);
    check(c2o_a, 1'b0, "R8 deselected pulse itself keeps low");
    en_pulse(1'b1);
    check(c2o_a, 1'b1, "R8 restored after deselected pulse");

    // R9: write strobe role.
    set_b(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    c1 = 1'b0; cyc(4);
    en_pulse(1'b1);
    rd_tick();
    rise_tick(1'b1); fall_tick(1'b1);
    check(c2o_b, 1'b1, "R9 read does not launch write strobe");
    wr_tick();
    fall_tick(1'b1);
    check(c2o_b, 1'b1, "R9 falling tick ignored");
    rise_tick(1'b1);
    check(c2o_b, 1'b0, "R9 low after rising tick");
    fall_tick(1'b1);
    c1 = 1'b1; cyc(3);
    check(c2o_b, 1'b1, "R9 restored by C1 edge");
    set_b(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    wr_tick();
    rise_tick(1'b1);
    check(c2o_b, 1'b0, "R9 enable-restore strobe low");
    fall_tick(1'b1);
    rise_tick(1'b1);
    check(c2o_b, 1'b0, "R9 held low without deselect");
    fall_tick(1'b1);
    rise_tick(1'b0); fall_tick(1'b0);
    check(c2o_b, 1'b0, "R9 low through deselected pulse");
    rise_tick(1'b1);
    check(c2o_b, 1'b1, "R9 restored after deselected pulse");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule